// File: doc/BRIEF.md
# Unified Byte-Addressed Memory with I/O Decode

This block is the shared storage of a small 32-bit processor. It has two read paths into one word array: an instruction fetch port that always returns whole aligned words, and a data port that loads and stores bytes, halfwords or words. Both read paths are registered, so read data appears on the clock edge after the address is presented.

The data port splits its address space at a fixed limit. Addresses up to and including 0x0000FFFF go to the internal RAM. Any higher address goes to a memory-mapped peripheral bus. On that bus the block presents the address and the store data, and it raises a write strobe for each cycle in which a store targets that range. Loads from the bus capture the peripheral input word on the clock edge. That word is then sized and extended in the same way as RAM data. Input and output travel on separate wires, so one bus address can serve as both an input and an output.

The storage depth is a parameter. With `RAM_WORD_BITS` set to 14 the array holds the full 64 KiB window as 16384 words. The default is smaller, and RAM addresses then wrap modulo the array size.

Top module: `memio_unit`

## Requirements
- R1: While reset is high, and after it falls until the next enabled read, `instrData` and `dataRdData` are zero.
- R2: A fetch with `instrRdEn` high returns, on the next clock edge, the 32-bit word that contains `instrAddr`; address bits 1:0 are ignored.
- R3: Word accesses to RAM are little-endian: the byte at address A+0 sits in bits 7:0 and the byte at A+3 in bits 31:24; a word load returns the stored word one clock after the address.
- R4: A byte store (`dataSize` = 0) writes only the lane selected by address bits 1:0, taking the value from `dataWrData[7:0]`.
- R5: A halfword store (`dataSize` = 1) writes only the two lanes selected by address bit 1, taking the value from `dataWrData[15:0]`.
- R6: Byte and halfword loads with `dataUnsigned` = 0 are sign-extended to 32 bits.
- R7: Byte and halfword loads with `dataUnsigned` = 1 are zero-extended to 32 bits.
- R8: A store to an address above 0x0000FFFF raises `ioWrStrobe` in that same cycle, with `ioAddr` equal to `dataAddr` and `ioWrData` equal to `dataWrData`. The RAM is left unchanged.
- R9: A load from an address above 0x0000FFFF returns `ioRdData` as sampled on the load's clock edge. It is sized and extended by the same rules as a RAM load.
- R10: `ioWrStrobe` is low whenever no store is presented or the store address is at or below 0x0000FFFF; address 0x0000FFFF is RAM.
- R11: While its read enable is low, each read output holds its last value, whatever happens to the address inputs.
- R12: A fetch of a word in the same cycle as a store to that word returns the contents from before the store.
- R13: Both ports use one storage array: a word written through the data port is returned by a later fetch of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the read registers |
| instrRdEn | input | 1 | Fetch enable |
| instrAddr | input | 32 | Fetch byte address (bits 1:0 ignored) |
| instrData | output | 32 | Registered fetched word |
| dataRdEn | input | 1 | Load enable |
| dataWrEn | input | 1 | Store enable |
| dataAddr | input | 32 | Data byte address |
| dataSize | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| dataUnsigned | input | 1 | 1 selects zero extension on sub-word loads |
| dataWrData | input | 32 | Store data, right-aligned |
| dataRdData | output | 32 | Registered, extended load result |
| ioAddr | output | 32 | Peripheral bus address |
| ioWrData | output | 32 | Peripheral bus write data |
| ioWrStrobe | output | 1 | Peripheral write strobe |
| ioRdData | input | 32 | Peripheral bus read data |

## Verification
The bench probes each lane of a word whose bytes have mixed top bits. A design with the lanes swapped, or with sign and zero extension confused, returns the wrong byte or the wrong upper bits. The addresses 0xFFFF and 0x10000 sit on either side of the decode limit. An off-by-one comparison would strobe the bus for a RAM byte, or would write RAM for a bus store. A bus store whose address wraps onto a preloaded RAM word shows whether a design writes RAM as well as the bus. A fetch in the same cycle as a store to the same word shows whether a design forwards the new data instead of returning the old contents. Further checks cover outputs that must hold while the read enables are low, and sub-word stores that must leave the neighbouring bytes untouched.

// File: rtl/memio_pkg.sv
package memio_pkg;
  localparam int WORD_W = 32;
  localparam int LANES = WORD_W / 8;
  localparam int OFS_W = $clog2(LANES);

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef struct packed {
    logic             ramWrite;
    logic             loadCapture;
    logic             loadFromIo;
    logic [LANES-1:0] laneMask;
  } memCtrl_t;
endpackage

// File: rtl/memio_ctrl.sv
module memio_ctrl
  import memio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 32'h0000FFFF
) (
  input  logic              dataRdEn,
  input  logic              dataWrEn,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [1:0]        dataSize,
  output memCtrl_t          ctrl,
  output logic              ioWrStrobe
);
  logic isIo;
  logic [LANES-1:0] mask;

  assign isIo = dataAddr > IO_LIMIT;

  always_comb begin
    unique case (dataSize)
      SIZE_BYTE: mask = LANES'(1) << dataAddr[OFS_W-1:0];
      SIZE_HALF: mask = LANES'(3) << {dataAddr[OFS_W-1], 1'b0};
      default:   mask = '1;
    endcase
  end

  always_comb begin
    ctrl.ramWrite    = dataWrEn && !isIo;
    ctrl.loadCapture = dataRdEn;
    ctrl.loadFromIo  = isIo;
    ctrl.laneMask    = mask;
  end

  assign ioWrStrobe = dataWrEn && isIo;
endmodule

// File: rtl/memio_datapath.sv
module memio_datapath
  import memio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RAM_WORD_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  memCtrl_t          ctrl,
  input  logic              instrRdEn,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic [WORD_W-1:0] instrData,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [1:0]        dataSize,
  input  logic              dataUnsigned,
  input  logic [WORD_W-1:0] dataWrData,
  output logic [WORD_W-1:0] dataRdData,
  input  logic [WORD_W-1:0] ioRdData
);
  localparam int RAM_WORDS = 1 << RAM_WORD_BITS;

  logic [WORD_W-1:0] ramArray [RAM_WORDS];
  logic [RAM_WORD_BITS-1:0] dataIdx, instrIdx;
  logic [WORD_W-1:0] laneData;

  assign dataIdx  = dataAddr[OFS_W +: RAM_WORD_BITS];
  assign instrIdx = instrAddr[OFS_W +: RAM_WORD_BITS];

  // place right-aligned store data onto every lane it may land in
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (dataSize)
        SIZE_BYTE: laneData[g*8 +: 8] = dataWrData[7:0];
        SIZE_HALF: laneData[g*8 +: 8] = dataWrData[(g%2)*8 +: 8];
        default:   laneData[g*8 +: 8] = dataWrData[g*8 +: 8];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.ramWrite) begin
      for (int l = 0; l < LANES; l++) begin
        if (ctrl.laneMask[l]) ramArray[dataIdx][l*8 +: 8] <= laneData[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) instrData <= '0;
    else if (instrRdEn) instrData <= ramArray[instrIdx];
  end

  logic [WORD_W-1:0] loadWord;
  logic [OFS_W-1:0]  loadOfs;
  logic [1:0]        loadSize;
  logic              loadUns;

  always_ff @(posedge clk) begin
    if (rst) begin
      loadWord <= '0;
      loadOfs  <= '0;
      loadSize <= SIZE_WORD;
      loadUns  <= 1'b0;
    end else if (ctrl.loadCapture) begin
      loadWord <= ctrl.loadFromIo ? ioRdData : ramArray[dataIdx];
      loadOfs  <= dataAddr[OFS_W-1:0];
      loadSize <= dataSize;
      loadUns  <= dataUnsigned;
    end
  end

  logic [WORD_W-1:0] shifted;
  assign shifted = loadWord >> {loadOfs, 3'b000};

  always_comb begin
    unique case (loadSize)
      SIZE_BYTE: dataRdData = {{(WORD_W-8){!loadUns && shifted[7]}}, shifted[7:0]};
      SIZE_HALF: dataRdData = {{(WORD_W-16){!loadUns && shifted[15]}}, shifted[15:0]};
      default:   dataRdData = loadWord;
    endcase
  end
endmodule

// File: rtl/memio_unit.sv
module memio_unit
  import memio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RAM_WORD_BITS = 10,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 32'h0000FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrRdEn,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic [WORD_W-1:0] instrData,
  input  logic              dataRdEn,
  input  logic              dataWrEn,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [1:0]        dataSize,
  input  logic              dataUnsigned,
  input  logic [WORD_W-1:0] dataWrData,
  output logic [WORD_W-1:0] dataRdData,
  output logic [ADDR_W-1:0] ioAddr,
  output logic [WORD_W-1:0] ioWrData,
  output logic              ioWrStrobe,
  input  logic [WORD_W-1:0] ioRdData
);
  memCtrl_t ctrl;

  memio_ctrl #(.ADDR_W(ADDR_W), .IO_LIMIT(IO_LIMIT)) u_ctrl (
    .dataRdEn(dataRdEn), .dataWrEn(dataWrEn), .dataAddr(dataAddr),
    .dataSize(dataSize), .ctrl(ctrl), .ioWrStrobe(ioWrStrobe)
  );

  memio_datapath #(.ADDR_W(ADDR_W), .RAM_WORD_BITS(RAM_WORD_BITS)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .instrRdEn(instrRdEn), .instrAddr(instrAddr), .instrData(instrData),
    .dataAddr(dataAddr), .dataSize(dataSize), .dataUnsigned(dataUnsigned),
    .dataWrData(dataWrData), .dataRdData(dataRdData), .ioRdData(ioRdData)
  );

  assign ioAddr   = dataAddr;
  assign ioWrData = dataWrData;
endmodule

// File: rtl/memio_unit_chk.sv
module memio_unit_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 32'h0000FFFF
) (
  input logic              clk,
  input logic              rst,
  input logic              instrRdEn,
  input logic [31:0]       instrData,
  input logic              dataRdEn,
  input logic              dataWrEn,
  input logic [ADDR_W-1:0] dataAddr,
  input logic [1:0]        dataSize,
  input logic              dataUnsigned,
  input logic [31:0]       dataRdData,
  input logic              ioWrStrobe,
  input logic [31:0]       ioRdData
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (instrData == '0 && dataRdData == '0));

  assert_io_store_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (dataWrEn && dataAddr > IO_LIMIT) |-> ioWrStrobe);

  assert_no_ram_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    (!dataWrEn || dataAddr <= IO_LIMIT) |-> !ioWrStrobe);

  assert_io_word_load_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dataRdEn) && $past(dataAddr) > IO_LIMIT && $past(dataSize) == 2'd2)
      |-> dataRdData == $past(ioRdData));

  assert_byte_sign_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dataRdEn) && $past(dataSize) == 2'd0 && !$past(dataUnsigned))
      |-> (dataRdData[31:8] == {24{dataRdData[7]}}));

  assert_byte_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dataRdEn) && $past(dataSize) == 2'd0 && $past(dataUnsigned))
      |-> (dataRdData[31:8] == '0));

  assert_fetch_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(instrRdEn)) |-> $stable(instrData));

  assert_load_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dataRdEn)) |-> $stable(dataRdData));
endmodule

bind memio_unit memio_unit_chk #(.ADDR_W(ADDR_W), .IO_LIMIT(IO_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .instrRdEn(instrRdEn), .instrData(instrData),
  .dataRdEn(dataRdEn), .dataWrEn(dataWrEn), .dataAddr(dataAddr),
  .dataSize(dataSize), .dataUnsigned(dataUnsigned), .dataRdData(dataRdData),
  .ioWrStrobe(ioWrStrobe), .ioRdData(ioRdData)
);

// File: tb/test_memio_unit.sv
module test_memio_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instrRdEn = 1'b0;
  logic [31:0] instrAddr = '0;
  logic [31:0] instrData;
  logic dataRdEn = 1'b0, dataWrEn = 1'b0;
  logic [31:0] dataAddr = '0;
  logic [1:0] dataSize = 2'd2;
  logic dataUnsigned = 1'b0;
  logic [31:0] dataWrData = '0;
  logic [31:0] dataRdData;
  logic [31:0] ioAddr, ioWrData;
  logic ioWrStrobe;
  logic [31:0] ioRdData = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memio_unit i_memio_unit (
    .clk(clk), .rst(rst), .instrRdEn(instrRdEn), .instrAddr(instrAddr),
    .instrData(instrData), .dataRdEn(dataRdEn), .dataWrEn(dataWrEn),
    .dataAddr(dataAddr), .dataSize(dataSize), .dataUnsigned(dataUnsigned),
    .dataWrData(dataWrData), .dataRdData(dataRdData), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioWrStrobe(ioWrStrobe), .ioRdData(ioRdData)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        uns;
    logic [31:0] expect_;
  } loadVec_t;

  // word at 0x100 holds 0x80FF7F01, word at 0xFFFC holds 0x12345678
  localparam loadVec_t VEC [0:9] = '{
    '{32'h0000_0100, 2'd2, 1'b0, 32'h80FF7F01},  // R3 word
    '{32'h0000_0100, 2'd0, 1'b0, 32'h00000001},  // R6 byte lane 0
    '{32'h0000_0101, 2'd0, 1'b0, 32'h0000007F},  // R6 byte lane 1
    '{32'h0000_0102, 2'd0, 1'b0, 32'hFFFFFFFF},  // R6 byte lane 2
    '{32'h0000_0103, 2'd0, 1'b1, 32'h00000080},  // R7 byte lane 3
    '{32'h0000_0103, 2'd0, 1'b0, 32'hFFFFFF80},  // R6 byte lane 3
    '{32'h0000_0100, 2'd1, 1'b0, 32'h00007F01},  // R6 low half
    '{32'h0000_0102, 2'd1, 1'b0, 32'hFFFF80FF},  // R6 high half
    '{32'h0000_0102, 2'd1, 1'b1, 32'h000080FF},  // R7 high half
    '{32'h0000_FFFF, 2'd0, 1'b1, 32'h00000012}   // R7 top RAM byte
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic storeOp(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    dataAddr = a; dataSize = sz; dataWrData = d; dataWrEn = 1'b1;
    @(negedge clk);
    dataWrEn = 1'b0;
  endtask

  task automatic loadOp(input logic [31:0] a, input logic [1:0] sz, input logic u,
                        output logic [31:0] res);
    @(negedge clk);
    dataAddr = a; dataSize = sz; dataUnsigned = u; dataRdEn = 1'b1;
    @(negedge clk);
    dataRdEn = 1'b0;
    res = dataRdData;
  endtask

  task automatic fetchOp(input logic [31:0] a, output logic [31:0] res);
    @(negedge clk);
    instrAddr = a; instrRdEn = 1'b1;
    @(negedge clk);
    instrRdEn = 1'b0;
    res = instrData;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R1 instrData in reset", instrData, 32'h0);
    check("R1 dataRdData in reset", dataRdData, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 instrData after reset", instrData, 32'h0);
    check("R1 dataRdData after reset", dataRdData, 32'h0);

    // preload through the data port
    storeOp(32'h0000_0100, 2'd2, 32'h80FF7F01);
    storeOp(32'h0000_FFFC, 2'd2, 32'h12345678);
    storeOp(32'h0000_0200, 2'd2, 32'h11223344);
    storeOp(32'h0000_0004, 2'd2, 32'h55AA55AA);
    storeOp(32'h0000_0300, 2'd2, 32'h01020304);

    for (int i = 0; i < 10; i++) begin
      loadOp(VEC[i].addr, VEC[i].size, VEC[i].uns, r);
      check(VEC[i].size == 2'd2 ? "R3 table load" :
            (VEC[i].uns ? "R7 table load" : "R6 table load"), r, VEC[i].expect_);
    end

    // R4 byte lane write
    storeOp(32'h0000_0201, 2'd0, 32'hFFFF_FFAB);
    loadOp(32'h0000_0200, 2'd2, 1'b0, r);
    check("R4 byte store lane 1", r, 32'h1122AB44);
    // R5 halfword lane write
    storeOp(32'h0000_0202, 2'd1, 32'h0000_BEEF);
    loadOp(32'h0000_0200, 2'd2, 1'b0, r);
    check("R5 half store upper", r, 32'hBEEFAB44);

    // R2 / R13 fetch of data-written word, low bits ignored
    fetchOp(32'h0000_0203, r);
    check("R2 R13 fetch unaligned address", r, 32'hBEEFAB44);

    // R11 hold while enables low
    @(negedge clk);
    instrAddr = 32'h0000_0100; dataAddr = 32'h0000_FFFC;
    repeat (3) @(negedge clk);
    check("R11 fetch hold", instrData, 32'hBEEFAB44);
    check("R11 load hold", dataRdData, 32'hBEEFAB44);

    // R8 store to the bus, RAM alias untouched
    @(negedge clk);
    dataAddr = 32'h0001_0004; dataSize = 2'd2; dataWrData = 32'hCAFE0001; dataWrEn = 1'b1;
    #1;
    check("R8 ioWrStrobe", {31'h0, ioWrStrobe}, 32'h1);
    check("R8 ioAddr", ioAddr, 32'h0001_0004);
    check("R8 ioWrData", ioWrData, 32'hCAFE0001);
    @(negedge clk);
    dataWrEn = 1'b0;
    #1;
    check("R10 strobe idle", {31'h0, ioWrStrobe}, 32'h0);
    loadOp(32'h0000_0004, 2'd2, 1'b0, r);
    check("R8 RAM unchanged by bus store", r, 32'h55AA55AA);

    // R10 boundary store stays in RAM
    @(negedge clk);
    dataAddr = 32'h0000_FFFF; dataSize = 2'd0; dataWrData = 32'h0000_00C3; dataWrEn = 1'b1;
    #1;
    check("R10 no strobe at limit", {31'h0, ioWrStrobe}, 32'h0);
    @(negedge clk);
    dataWrEn = 1'b0;
    loadOp(32'h0000_FFFC, 2'd2, 1'b0, r);
    check("R10 limit byte in RAM", r, 32'hC3345678);

    // R9 loads from the bus
    ioRdData = 32'h0000_80F0;
    loadOp(32'h0001_0000, 2'd0, 1'b0, r);
    check("R9 bus byte signed", r, 32'hFFFFFFF0);
    loadOp(32'h0002_0000, 2'd2, 1'b0, r);
    check("R9 bus word", r, 32'h000080F0);
    loadOp(32'h0001_0000, 2'd1, 1'b1, r);
    check("R9 bus half unsigned", r, 32'h000080F0);

    // R12 fetch and store to the same word in one cycle
    @(negedge clk);
    dataAddr = 32'h0000_0300; dataSize = 2'd2; dataWrData = 32'hA5A5A5A5; dataWrEn = 1'b1;
    instrAddr = 32'h0000_0300; instrRdEn = 1'b1;
    @(negedge clk);
    dataWrEn = 1'b0; instrRdEn = 1'b0;
    check("R12 fetch returns old word", instrData, 32'h01020304);
    fetchOp(32'h0000_0300, r);
    check("R13 fetch sees new word", r, 32'hA5A5A5A5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule